// File: doc/BRIEF.md
# AC-link Output Frame Transmitter

This block is the controller side of an AC-link playback path. It builds each 256-bit output frame and shifts it out one bit per bit clock, with the most significant bit first. Each frame has a 16-bit tag slot followed by twelve 20-bit slots. A sync pulse marks the tag slot. The block takes at most one register access per frame, plus a left and a right PCM sample, each with its own valid flag. It writes the tag bits and the codec ID, and it drives every reserved or unused bit position to zero.

A requester offers a command on `cmd_valid_i`. The command is accepted only in the cycle in which `cmd_ready_o` is high, which is the last bit clock of the current frame. The PCM inputs are sampled in that same cycle. The frame that starts on the next clock edge carries what was sampled. A command whose codec ID is zero goes to the primary codec. A non-zero ID selects a secondary codec: the two command tag bits are then forced to zero and the ID alone does the addressing. A frame with no command is sent to the primary codec.

Top module: `acl_out_tx`

## Requirements
- R1: While reset is held, `sync_o` and `sdata_o` are low and `cmd_ready_o` is high. The first frame begins on the first clock edge after reset is released.
- R2: A frame lasts 256 bit clocks. `sync_o` is high for the first 16 of them, and `cmd_ready_o` is high in exactly the last one.
- R3: The frame bits leave on `sdata_o` MSB first, one bit per rising edge. The tag comes first, then slots 1 to 12. Bit index k of a frame (k = 0 for tag bit 15) is on `sdata_o` in the k-th clock of that frame.
- R4: Tag bit 15 is 1 exactly when the frame carries a command, a valid left sample or a valid right sample.
- R5: For a primary target (command ID 0), tag bit 14 is 1 when a command is present. Tag bit 13 is 1 when the command is a write. Tag bits 1:0 are 0.
- R6: For a secondary target (command ID 1 to 3), tag bits 14 and 13 are 0 and tag bits 1:0 carry the ID.
- R7: Tag bit 12 is the left valid flag and tag bit 11 is the right valid flag. Tag bits 10:2 are always 0.
- R8: Slot 1 holds the read flag in bit 19 (1 = read) and the 7-bit address in bits 18:12. Bits 11:0 are 0.
- R9: For a write, slot 2 holds the 16-bit data in bits 19:4 and bits 3:0 are 0. For a read, all of slot 2 is 0 whatever is on the data input.
- R10: Slots 3 and 4 hold the left and right samples (MSB justified) when those are valid, and zero otherwise. Slots 5 to 12 are always zero.
- R11: A command or PCM input offered in any cycle other than the ready cycle has no effect on any frame.
- R12: When no command is accepted, slots 1 and 2 and tag bits 14, 13 and 1:0 are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | A register access is offered |
| cmd_ready_o | output | 1 | Last bit clock of the frame; command and PCM are sampled now |
| cmd_rd_i | input | 1 | 1 = read access, 0 = write access |
| cmd_addr_i | input | 7 | Register address |
| cmd_wdata_i | input | 16 | Write data |
| cmd_id_i | input | 2 | Target codec ID, 0 = primary |
| pcm_l_valid_i | input | 1 | Left sample valid |
| pcm_l_i | input | 20 | Left PCM sample |
| pcm_r_valid_i | input | 1 | Right sample valid |
| pcm_r_i | input | 20 | Right PCM sample |
| sync_o | output | 1 | Frame sync, high during the tag slot |
| sdata_o | output | 1 | Serial frame data, MSB first |

## Verification
Some properties are checked on every cycle. The ready pulse lasts a single cycle once per frame, and sync always rises just after it. The tag padding bits and slots 5 to 12 are always zero. Tag bit 15 follows what was offered in the ready cycle, and a secondary target always clears the two command bits. The exact slot contents can only be shown by the bench's scenarios, which rebuild each frame from the sampled inputs and compare it field by field. These contents are the address and data placement, the read and write zeroing, PCM masking by the valid flags, and the codec ID placement. The scenarios also show that commands offered mid-frame are dropped.

// File: rtl/acl_out_pkg.sv
package acl_out_pkg;
  localparam int TAG_W      = 16;
  localparam int SLOT_W     = 20;
  localparam int DATA_SLOTS = 12;
  localparam int ADDR_W     = 7;
  localparam int REG_W      = 16;
  localparam int ID_W       = 2;
  localparam int PCM_W      = 20;
  localparam int FRAME_W    = TAG_W + DATA_SLOTS * SLOT_W;

  // tag bit positions decoded by the codec
  localparam int TB_FRAME = 15;
  localparam int TB_CADDR = 14;
  localparam int TB_CDATA = 13;
  localparam int TB_PCM_L = 12;
  localparam int TB_PCM_R = 11;

  typedef struct packed {
    logic              rd;
    logic [ADDR_W-1:0] addr;
    logic [REG_W-1:0]  data;
    logic [ID_W-1:0]   id;
  } reg_cmd_t;
endpackage

// File: rtl/acl_out_frame_ctr.sv
module acl_out_frame_ctr #(
  parameter int FRAME_W = 256,
  parameter int TAG_W   = 16,
  parameter int CNT_W   = $clog2(FRAME_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [CNT_W-1:0] bit_idx_o,
  output logic             load_o,
  output logic             sync_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             sync_q;

  assign cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;

  // reset parks on the last bit so the first frame loads right after release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= LAST;
      sync_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      sync_q <= (cnt_d < CNT_W'(TAG_W));
    end
  end

  assign bit_idx_o = cnt_q;
  assign load_o    = (cnt_q == LAST);
  assign sync_o    = sync_q;

  p_ready_once_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> !load_o);
  p_sync_after_ready_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sync_o) |-> $past(load_o));
endmodule

// File: rtl/acl_out_frame_build.sv
module acl_out_frame_build
  import acl_out_pkg::*;
#(
  parameter int PCM_BITS = PCM_W
) (
  input  logic                cmd_valid_i,
  input  reg_cmd_t            cmd_i,
  input  logic                pcm_l_valid_i,
  input  logic [PCM_BITS-1:0] pcm_l_i,
  input  logic                pcm_r_valid_i,
  input  logic [PCM_BITS-1:0] pcm_r_i,
  output logic [FRAME_W-1:0]  frame_o
);
  logic [SLOT_W-1:0] l_word, r_word;

  // samples sit MSB justified in the slot, low bits stuffed with zero
  if (PCM_BITS == SLOT_W) begin : g_pcm_full
    assign l_word = pcm_l_i;
    assign r_word = pcm_r_i;
  end else begin : g_pcm_pad
    assign l_word = {pcm_l_i, {(SLOT_W - PCM_BITS){1'b0}}};
    assign r_word = {pcm_r_i, {(SLOT_W - PCM_BITS){1'b0}}};
  end

  logic              is_sec, is_wr;
  logic [TAG_W-1:0]  tag;
  logic [SLOT_W-1:0] slot [1:DATA_SLOTS];

  assign is_sec = cmd_valid_i && (cmd_i.id != '0);
  assign is_wr  = cmd_valid_i && !cmd_i.rd;

  always_comb begin
    tag           = '0;
    tag[TB_FRAME] = cmd_valid_i | pcm_l_valid_i | pcm_r_valid_i;
    tag[TB_CADDR] = cmd_valid_i && !is_sec;
    tag[TB_CDATA] = is_wr && !is_sec;
    tag[TB_PCM_L] = pcm_l_valid_i;
    tag[TB_PCM_R] = pcm_r_valid_i;
    tag[ID_W-1:0] = cmd_valid_i ? cmd_i.id : '0;
  end

  always_comb begin
    for (int s = 1; s <= DATA_SLOTS; s++) slot[s] = '0;
    if (cmd_valid_i) slot[1] = {cmd_i.rd, cmd_i.addr, {(SLOT_W - 1 - ADDR_W){1'b0}}};
    if (is_wr)       slot[2] = {cmd_i.data, {(SLOT_W - REG_W){1'b0}}};
    if (pcm_l_valid_i) slot[3] = l_word;
    if (pcm_r_valid_i) slot[4] = r_word;
  end

  always_comb begin
    frame_o = '0;
    frame_o[FRAME_W-1 -: TAG_W] = tag;
    for (int s = 1; s <= DATA_SLOTS; s++)
      frame_o[FRAME_W - TAG_W - (s - 1) * SLOT_W - 1 -: SLOT_W] = slot[s];
  end
endmodule

// File: rtl/acl_out_shifter.sv
module acl_out_shifter #(
  parameter int FRAME_W = 256
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [FRAME_W-1:0] frame_i,
  output logic               sdata_o
);
  logic [FRAME_W-1:0] shift_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     shift_q <= '0;
    else if (load_i) shift_q <= frame_i;
    else             shift_q <= {shift_q[FRAME_W-2:0], 1'b0};
  end

  assign sdata_o = shift_q[FRAME_W-1];
endmodule

// File: rtl/acl_out_tx.sv
module acl_out_tx
  import acl_out_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  output logic              cmd_ready_o,
  input  logic              cmd_rd_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic [REG_W-1:0]  cmd_wdata_i,
  input  logic [ID_W-1:0]   cmd_id_i,
  input  logic              pcm_l_valid_i,
  input  logic [PCM_W-1:0]  pcm_l_i,
  input  logic              pcm_r_valid_i,
  input  logic [PCM_W-1:0]  pcm_r_i,
  output logic              sync_o,
  output logic              sdata_o
);
  localparam int CNT_W     = $clog2(FRAME_W);
  localparam int PAD_FIRST = TAG_W - 1 - (TB_PCM_R - 1);
  localparam int PAD_LAST  = TAG_W - 1 - ID_W;
  localparam int TAIL_FROM = TAG_W + 4 * SLOT_W;

  logic [CNT_W-1:0]   bit_idx;
  logic               load;
  logic [FRAME_W-1:0] frame;
  reg_cmd_t           cmd;

  assign cmd = '{rd: cmd_rd_i, addr: cmd_addr_i, data: cmd_wdata_i, id: cmd_id_i};

  acl_out_frame_ctr #(.FRAME_W(FRAME_W), .TAG_W(TAG_W), .CNT_W(CNT_W)) u_ctr (
    .clk_i, .rst_ni, .bit_idx_o(bit_idx), .load_o(load), .sync_o(sync_o)
  );

  acl_out_frame_build #(.PCM_BITS(PCM_W)) u_build (
    .cmd_valid_i, .cmd_i(cmd), .pcm_l_valid_i, .pcm_l_i,
    .pcm_r_valid_i, .pcm_r_i, .frame_o(frame)
  );

  acl_out_shifter #(.FRAME_W(FRAME_W)) u_shift (
    .clk_i, .rst_ni, .load_i(load), .frame_i(frame), .sdata_o(sdata_o)
  );

  assign cmd_ready_o = load;

  p_tag_any_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load |=> (sdata_o == $past(cmd_valid_i | pcm_l_valid_i | pcm_r_valid_i)));
  p_sec_caddr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load && cmd_valid_i && cmd_id_i != '0) |=> ##1 !sdata_o);
  p_sec_cdata_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load && cmd_valid_i && cmd_id_i != '0) |=> ##2 !sdata_o);
  p_tag_pad_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_o && bit_idx >= CNT_W'(PAD_FIRST) && bit_idx <= CNT_W'(PAD_LAST)) |-> !sdata_o);
  p_tail_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_idx >= CNT_W'(TAIL_FROM)) |-> !sdata_o);
endmodule

// File: tb/acl_out_tx_tb_top.sv
`timescale 1ns/1ps
module acl_out_tx_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cmd_valid_i = 1'b0, cmd_rd_i = 1'b0;
  logic [6:0]  cmd_addr_i = '0;
  logic [15:0] cmd_wdata_i = '0;
  logic [1:0]  cmd_id_i = '0;
  logic        pcm_l_valid_i = 1'b0, pcm_r_valid_i = 1'b0;
  logic [19:0] pcm_l_i = '0, pcm_r_i = '0;
  logic        cmd_ready_o, sync_o, sdata_o;

  int checks = 0, fails = 0, sent = 0, frames_done = 0;
  logic [255:0] expq [$];

  always #2 clk_i = ~clk_i;

  acl_out_tx dut_i (.*);

  task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [255:0] exp_frame(input bit cv, input bit rd, input logic [6:0] a,
      input logic [15:0] d, input logic [1:0] id, input bit lv, input logic [19:0] l,
      input bit rv, input logic [19:0] r);
    logic [15:0] t;
    logic [19:0] s1, s2, s3, s4;
    bit prim;
    prim = cv && (id == 2'd0);
    t  = {(cv || lv || rv), prim, prim && !rd, lv, rv, 9'b0, (cv ? id : 2'b00)};
    s1 = cv ? {rd, a, 12'b0} : 20'b0;
    s2 = (cv && !rd) ? {d, 4'b0} : 20'b0;
    s3 = lv ? l : 20'b0;
    s4 = rv ? r : 20'b0;
    return {t, s1, s2, s3, s4, 160'b0};
  endfunction

  // driver: offers one frame's worth of stimulus at the ready cycle
  task automatic send(input bit cv, input bit rd, input logic [6:0] a, input logic [15:0] d,
      input logic [1:0] id, input bit lv, input logic [19:0] l, input bit rv,
      input logic [19:0] r, input bit junk);
    while (!cmd_ready_o) @(negedge clk_i);
    cmd_valid_i = cv; cmd_rd_i = rd; cmd_addr_i = a; cmd_wdata_i = d; cmd_id_i = id;
    pcm_l_valid_i = lv; pcm_l_i = l; pcm_r_valid_i = rv; pcm_r_i = r;
    expq.push_back(exp_frame(cv, rd, a, d, id, lv, l, rv, r));
    sent++;
    @(negedge clk_i);
    cmd_valid_i = 1'b0; pcm_l_valid_i = 1'b0; pcm_r_valid_i = 1'b0;
    if (junk) begin  // R11: mid-frame offers must be dropped
      repeat (40) @(negedge clk_i);
      cmd_valid_i = 1'b1; cmd_rd_i = 1'b0; cmd_addr_i = 7'h11; cmd_wdata_i = 16'hdead;
      cmd_id_i = 2'd2; pcm_l_valid_i = 1'b1; pcm_r_valid_i = 1'b1;
      repeat (30) @(negedge clk_i);
      cmd_valid_i = 1'b0; pcm_l_valid_i = 1'b0; pcm_r_valid_i = 1'b0;
    end
  endtask

  // monitor: deserializes each frame and compares it field by field
  initial begin
    int idx;
    bit in_f, prev, sync_bad, rdy_bad;
    logic [255:0] got, exp;
    idx = 0; in_f = 0; prev = 0; sync_bad = 0; rdy_bad = 0; got = '0;
    forever begin
      @(negedge clk_i);
      if (!rst_ni) begin
        prev = 0; in_f = 0;
      end else begin
        if (sync_o && !prev) begin
          in_f = 1; idx = 0; sync_bad = 0; rdy_bad = 0; got = '0;
        end
        if (in_f) begin
          got[255-idx] = sdata_o;
          if (sync_o != (idx < 16)) sync_bad = 1;
          if (cmd_ready_o != (idx == 255)) rdy_bad = 1;
          idx++;
          if (idx == 256) begin
            exp = (expq.size() != 0) ? expq.pop_front() : '0;
            chk("R2 sync window", 256'(sync_bad), 256'(0));
            chk("R2 ready pulse", 256'(rdy_bad), 256'(0));
            chk("R3 R4 R5 R6 R7 R12 tag", 256'(got[255:240]), 256'(exp[255:240]));
            chk("R8 R12 slot1", 256'(got[239:220]), 256'(exp[239:220]));
            chk("R9 R12 slot2", 256'(got[219:200]), 256'(exp[219:200]));
            chk("R10 slot3", 256'(got[199:180]), 256'(exp[199:180]));
            chk("R10 slot4", 256'(got[179:160]), 256'(exp[179:160]));
            chk("R10 tail slots", 256'(got[159:0]), 256'(exp[159:0]));
            chk("R11 R3 whole frame", got, exp);
            in_f = 0;
            frames_done++;
          end
        end
        prev = sync_o;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 reset outputs", 256'({sync_o, sdata_o, cmd_ready_o}), 256'(3'b001));
    rst_ni = 1'b1;
    // idle frame, stale data on inputs (R12, R10)
    send(0, 0, 7'h33, 16'hffff, 2'd1, 0, 20'hfffff, 0, 20'habcde, 0);
    // primary write
    send(1, 0, 7'h02, 16'h8080, 2'd0, 0, 20'h12345, 0, 20'h0, 0);
    // primary read with data on the bus, left only (R9)
    send(1, 1, 7'h7c, 16'hffff, 2'd0, 1, 20'h80001, 0, 20'hfffff, 0);
    // secondary write, both samples (R6)
    send(1, 0, 7'h55, 16'ha5c3, 2'd1, 1, 20'h0f0f0, 1, 20'h33333, 0);
    // secondary read id 3
    send(1, 1, 7'h7f, 16'h1234, 2'd3, 0, 20'h0, 0, 20'h0, 0);
    // PCM only, extremes
    send(0, 1, 7'h7f, 16'hffff, 2'd3, 1, 20'hfffff, 1, 20'h00001, 1);
    // right only, mid-frame junk offered afterwards (R11)
    send(0, 0, 7'h00, 16'h0, 2'd0, 0, 20'h11111, 1, 20'h7ffff, 1);
    // idle frame following junk
    send(0, 0, 7'h00, 16'h0, 2'd0, 0, 20'h0, 0, 20'h0, 0);
    // secondary id 2 write, full data
    send(1, 0, 7'h00, 16'hffff, 2'd2, 1, 20'hc0000, 0, 20'h0, 0);
    // primary write, max address, both samples
    send(1, 0, 7'h7f, 16'h0001, 2'd0, 1, 20'h00010, 1, 20'hf0000, 0);
    while (frames_done < sent) @(negedge clk_i);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule